// File: doc/BRIEF.md
# Four-Buffer Trace Write Ring Sequencer

The block sits between a trace record formatter and a simple word-write memory port. Software programs four base addresses and one common buffer size, then enables tracing. Every record word that the formatter offers is passed through as a write request. Its address is the base of the current buffer plus a running byte offset. The buffers are filled strictly in the order 0, 1, 2, 3. After buffer 3 the ring returns to buffer 0 for as long as tracing stays enabled.

Each time a buffer fills, the block emits a one-cycle completion pulse with the buffer index and sets a per-buffer status bit. Software clears a status bit by writing one to it. A level interrupt is raised while any status bit is set. If the ring advances into a buffer whose status bit has not been cleared, a sticky overflow flag is set. When tracing is disabled, the record in progress is finished and writing then stops. The current buffer index and offset stay visible until tracing is enabled again, and a new start always begins at buffer 0, offset 0.

The control is a four-state machine:
- IDLE: the state after reset.
- RUN: writing.
- DRAIN: finishing a record after disable.
- HALT: stopped with the position held.

The transitions are:
- IDLE->RUN and HALT->RUN on enable. These clear the position and the overflow flag.
- RUN->HALT on disable at a record boundary.
- RUN->DRAIN on disable in mid-record.
- DRAIN->HALT when the record's last word is accepted.

Top module: `trace_ring_seq`

## Requirements
- R1: Each accepted word is written to base[index] + offset. The offset is a byte count that grows by DATA_W/8 per accepted word.
- R2: When the offset would reach buf_size, the next word goes to the next buffer at offset 0. Buffers are used in the order 0,1,2,3, and after 3 the ring returns to buffer 0 while enabled.
- R3: buf_done is high for exactly the one cycle after the edge that accepts a buffer's final word. done_idx gives that buffer's index.
- R4: A buffer's status bit is set in the same cycle as its buf_done. A one in bit b of status_clr clears bit b, but a set on the same edge wins. irq is the OR of all status bits.
- R5: overflow is set when a buffer fills while trace_en is high and the status bit of the next buffer, after same-edge clears, is already set. overflow then stays set until tracing is started again.
- R6: If trace_en falls in mid-record, the remaining words of that record (REC_WORDS words per record) are still accepted. Writing then stops. At a record boundary, writing stops at once.
- R7: While stopped, rec_ready and wr_valid are low, offered words are ignored, and cur_idx and cur_off keep their values.
- R8: Enabling tracing from the stopped or reset state restarts at buffer 0, offset 0, and clears overflow.
- R9: While writing is permitted, wr_valid follows rec_valid, rec_ready follows wr_ready, and wr_data equals rec_data.
- R10: After reset, buf_done, buf_status, overflow, irq, cur_idx and cur_off are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Tracing enable level |
| buf_base | input | 4*ADDR_W | Base byte address of each of the four buffers |
| buf_size | input | SIZE_W | Common buffer size in bytes, a multiple of the record size |
| rec_valid | input | 1 | Formatter offers a record word |
| rec_data | input | DATA_W | Record word |
| rec_ready | output | 1 | Record word taken |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | DATA_W | Write data |
| wr_ready | input | 1 | Memory port accepts the write |
| status_clr | input | 4 | Write-one-to-clear for the buffer status bits |
| buf_done | output | 1 | One-cycle buffer-full pulse |
| done_idx | output | 2 | Index of the buffer that filled |
| buf_status | output | 4 | Per-buffer full status |
| overflow | output | 1 | Ring wrapped into an unacknowledged buffer |
| irq | output | 1 | Level interrupt, any status bit set |
| cur_idx | output | 2 | Current buffer index |
| cur_off | output | SIZE_W | Current byte offset in the buffer |

## Verification
The bench sweeps several buffer sizes, from one record per buffer up to four, with and without back-pressure on the write port. It runs past buffer 3 each time, so a design that wraps late, skips a buffer or straddles a record across buffers shows a wrong address. One sweep leaves every status bit set so that the wrap must raise overflow. Another holds all clear bits high so that a set must win over a clear and overflow must stay low. A design that compared against the stale bit would get these wrong. The stop case drops the enable after the first word of a record. A design that cut the record short, kept writing, lost its held offset, or restarted anywhere other than buffer 0, offset 0 produces a mismatch on the address or on the readable position.

// File: rtl/trs_pkg.sv
package trs_pkg;
    localparam int RING_BUFS  = 4;
    localparam int RING_IDX_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HALT  = 2'd3
    } ring_state_e;
endpackage

// File: rtl/trs_fsm.sv
module trs_fsm
    import trs_pkg::*;
#(
    parameter int SIZE_W     = 23,
    parameter int REC_WORDS  = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trace_en,
    input  logic                  rec_valid,
    input  logic                  wr_ready,
    input  logic [SIZE_W-1:0]     buf_size,
    output logic                  active,
    output logic                  fill,
    output logic                  start,
    output logic                  running,
    output logic [RING_IDX_W-1:0] idx,
    output logic [SIZE_W-1:0]     off,
    output logic                  done,
    output logic [RING_IDX_W-1:0] done_idx
);
    localparam int CNT_W = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(REC_WORDS - 1);

    ring_state_e      state, state_nx;
    logic [CNT_W-1:0] wcnt, wcnt_nx;
    logic [SIZE_W-1:0] off_inc;
    logic             accept;

    // output process: when the word stream may pass
    always_comb begin
        active = 1'b0;
        unique case (state)
            ST_RUN:   active = trace_en || (wcnt != '0);
            ST_DRAIN: active = 1'b1;
            ST_IDLE:  active = 1'b0;
            ST_HALT:  active = 1'b0;
            default:  active = 1'b0;
        endcase
    end

    assign accept  = active && rec_valid && wr_ready;
    assign off_inc = off + SIZE_W'(WORD_BYTES);
    assign fill    = accept && (off_inc == buf_size);
    assign wcnt_nx = accept ? ((wcnt == LAST_WORD) ? '0 : wcnt + 1'b1) : wcnt;
    assign start   = ((state == ST_IDLE) || (state == ST_HALT)) && trace_en;
    assign running = (state == ST_RUN) || (state == ST_DRAIN);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_HALT: if (trace_en) state_nx = ST_RUN;
            ST_RUN:   if (!trace_en) state_nx = (wcnt_nx == '0) ? ST_HALT : ST_DRAIN;
            ST_DRAIN: if (wcnt_nx == '0) state_nx = ST_HALT;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            off  <= '0;
            idx  <= '0;
        end else if (start) begin
            wcnt <= '0;
            off  <= '0;
            idx  <= '0;
        end else if (accept) begin
            wcnt <= wcnt_nx;
            off  <= fill ? '0 : off_inc;
            if (fill) idx <= idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            done_idx <= '0;
        end else begin
            done <= fill;
            if (fill) done_idx <= idx;
        end
    end
endmodule

// File: rtl/trs_addr.sv
module trs_addr
    import trs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 23
) (
    input  logic [RING_BUFS-1:0][ADDR_W-1:0] buf_base,
    input  logic [RING_IDX_W-1:0]            idx,
    input  logic [SIZE_W-1:0]                off,
    output logic [ADDR_W-1:0]                addr
);
    assign addr = buf_base[idx] + ADDR_W'(off);
endmodule

// File: rtl/trs_status.sv
module trs_status
    import trs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill,
    input  logic [RING_IDX_W-1:0] fill_idx,
    input  logic                  chk_en,
    input  logic                  start,
    input  logic [RING_BUFS-1:0]  clr,
    output logic [RING_BUFS-1:0]  status,
    output logic                  overflow
);
    logic [RING_BUFS-1:0]  kept;
    logic [RING_IDX_W-1:0] nxt;

    assign kept = status & ~clr;
    assign nxt  = fill_idx + 1'b1;

    for (genvar b = 0; b < RING_BUFS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                                   status[b] <= 1'b0;
            else if (fill && (fill_idx == RING_IDX_W'(b))) status[b] <= 1'b1;
            else                                          status[b] <= kept[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             overflow <= 1'b0;
        else if (start)                         overflow <= 1'b0;
        else if (fill && chk_en && kept[nxt])   overflow <= 1'b1;
    end
endmodule

// File: rtl/trace_ring_seq.sv
module trace_ring_seq
    import trs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SIZE_W    = 23,
    parameter int REC_WORDS = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             trace_en,
    input  logic [RING_BUFS-1:0][ADDR_W-1:0] buf_base,
    input  logic [SIZE_W-1:0]                buf_size,
    input  logic                             rec_valid,
    input  logic [DATA_W-1:0]                rec_data,
    output logic                             rec_ready,
    output logic                             wr_valid,
    output logic [ADDR_W-1:0]                wr_addr,
    output logic [DATA_W-1:0]                wr_data,
    input  logic                             wr_ready,
    input  logic [RING_BUFS-1:0]             status_clr,
    output logic                             buf_done,
    output logic [RING_IDX_W-1:0]            done_idx,
    output logic [RING_BUFS-1:0]             buf_status,
    output logic                             overflow,
    output logic                             irq,
    output logic [RING_IDX_W-1:0]            cur_idx,
    output logic [SIZE_W-1:0]                cur_off
);
    localparam int WORD_BYTES = DATA_W / 8;

    logic active, fill, start, running;

    trs_fsm #(
        .SIZE_W(SIZE_W), .REC_WORDS(REC_WORDS), .WORD_BYTES(WORD_BYTES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
        .rec_valid(rec_valid), .wr_ready(wr_ready), .buf_size(buf_size),
        .active(active), .fill(fill), .start(start), .running(running),
        .idx(cur_idx), .off(cur_off), .done(buf_done), .done_idx(done_idx)
    );

    trs_addr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_addr (
        .buf_base(buf_base), .idx(cur_idx), .off(cur_off), .addr(wr_addr)
    );

    trs_status u_status (
        .clk(clk), .rst_n(rst_n), .fill(fill), .fill_idx(cur_idx),
        .chk_en(trace_en), .start(start), .clr(status_clr),
        .status(buf_status), .overflow(overflow)
    );

    assign wr_valid  = active && rec_valid;
    assign rec_ready = active && wr_ready;
    assign wr_data   = rec_data;
    assign irq       = |buf_status;
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
    parameter int SIZE_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trace_en,
    input logic              running,
    input logic              buf_done,
    input logic [1:0]        done_idx,
    input logic [3:0]        buf_status,
    input logic              overflow,
    input logic [1:0]        cur_idx,
    input logic [SIZE_W-1:0] cur_off,
    input logic [SIZE_W-1:0] buf_size,
    input logic              rec_valid,
    input logic              wr_valid,
    input logic              rec_ready,
    input logic              wr_ready
);
    // R3 R4
    done_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |-> buf_status[done_idx]);

    // R2
    done_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |-> (cur_idx == done_idx + 2'd1));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_done |=> !buf_done || (buf_size == 4'(0)) || (buf_size <= 8));

    // R1
    off_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cur_off < buf_size));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !trace_en) |=> ($stable(cur_off) && $stable(cur_idx)));

    // R5
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && overflow) |=> overflow);

    // R9
    pass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> rec_valid);

    // R9
    pass_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ready |-> wr_ready);
endmodule

bind trace_ring_seq trs_checker #(.SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .running(running),
    .buf_done(buf_done), .done_idx(done_idx), .buf_status(buf_status),
    .overflow(overflow), .cur_idx(cur_idx), .cur_off(cur_off),
    .buf_size(buf_size), .rec_valid(rec_valid), .wr_valid(wr_valid),
    .rec_ready(rec_ready), .wr_ready(wr_ready)
);

// File: tb/tb_trace_ring_seq.sv
module tb_trace_ring_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int SIZE_W = 8;
    localparam int REC    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trace_en = 1'b0;
    logic [3:0][ADDR_W-1:0] buf_base;
    logic [SIZE_W-1:0] buf_size = 8'd8;
    logic rec_valid = 1'b0;
    logic [DATA_W-1:0] rec_data = '0;
    logic rec_ready, wr_valid, wr_ready;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [3:0] status_clr = 4'h0;
    logic buf_done, overflow, irq;
    logic [1:0] done_idx, cur_idx;
    logic [3:0] buf_status;
    logic [SIZE_W-1:0] cur_off;

    trace_ring_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .REC_WORDS(REC)) dut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .buf_base(buf_base),
        .buf_size(buf_size), .rec_valid(rec_valid), .rec_data(rec_data),
        .rec_ready(rec_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ready(wr_ready), .status_clr(status_clr),
        .buf_done(buf_done), .done_idx(done_idx), .buf_status(buf_status),
        .overflow(overflow), .irq(irq), .cur_idx(cur_idx), .cur_off(cur_off)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // write port back-pressure
    bit stall_mode = 1'b0;
    int cyc = 0;
    initial wr_ready = 1'b1;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 wr_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
    end

    // reference model, evaluated for the coming edge
    bit m_run = 0;
    int m_idx = 0, m_off = 0, m_wc = 0, m_didx = 0;
    logic [3:0] m_status = 4'h0;
    bit m_ovf = 0, m_done = 0;
    logic [31:0] m_seq = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] kept;
            bit allowed;
            chk("R3 buf_done", 32'(buf_done), 32'(m_done));
            if (m_done) chk("R3 done_idx", 32'(done_idx), 32'(m_didx));
            chk("R4 buf_status", 32'(buf_status), 32'(m_status));
            chk("R4 irq", 32'(irq), 32'(|m_status));
            chk("R5 overflow", 32'(overflow), 32'(m_ovf));
            chk("R2 cur_idx", 32'(cur_idx), 32'(m_idx));
            chk("R1 cur_off", 32'(cur_off), 32'(m_off));
            allowed = m_run && (trace_en || m_wc != 0);
            chk("R9 rec_ready", 32'(rec_ready), 32'(allowed && wr_ready));
            chk("R7 wr_valid", 32'(wr_valid), 32'(allowed && rec_valid));
            m_done = 0;
            kept = m_status & ~status_clr;
            if (!m_run) begin
                if (trace_en) begin
                    m_run = 1; m_idx = 0; m_off = 0; m_wc = 0; m_ovf = 0;
                end
            end else if (allowed && rec_valid && wr_ready) begin
                chk("R1 wr_addr", 32'(wr_addr), 32'(ADDR_W'(buf_base[m_idx] + ADDR_W'(m_off))));
                chk("R9 wr_data", wr_data, m_seq);
                m_seq++;
                m_off += 4;
                m_wc = (m_wc + 1) % REC;
                if (m_off == int'(buf_size)) begin
                    m_done = 1;
                    m_didx = m_idx;
                    if (trace_en && kept[(m_idx + 1) % 4]) m_ovf = 1;
                    kept[m_idx] = 1'b1;
                    m_idx = (m_idx + 1) % 4;
                    m_off = 0;
                end
            end
            m_status = kept;
            if (m_run && !trace_en && m_wc == 0) m_run = 0;
        end
    end

    logic [31:0] seq = 0;
    task automatic push();
        rec_valid = 1'b1;
        rec_data  = seq;
        @(negedge clk);
        while (!rec_ready) @(negedge clk);
        @(posedge clk);
        #1 rec_valid = 1'b0;
        seq++;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4; k++) buf_base[k] = ADDR_W'(16'h1000 * (k + 1));
        tick(4);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 buf_done", 32'(buf_done), 0);
        chk("R10 buf_status", 32'(buf_status), 0);
        chk("R10 overflow", 32'(overflow), 0);
        chk("R10 irq", 32'(irq), 0);
        chk("R10 cur_idx", 32'(cur_idx), 0);
        chk("R10 cur_off", 32'(cur_off), 0);
        tick(1);

        // R2 R5 sweep: sizes 1..4 records, five buffers, never acknowledged
        for (int s = 1; s <= 4; s++) begin
            buf_size = SIZE_W'(8 * s);
            for (int k = 0; k < 4; k++) buf_base[k] = ADDR_W'(16'h0400 * (k + 1) + 16'h40 * s);
            stall_mode = s[0];
            trace_en = 1'b1;
            tick(1);
            for (int r = 0; r < 5 * s; r++) repeat (REC) push();
            trace_en = 1'b0;
            tick(3);
            chk("R5 overflow after wrap", 32'(overflow), 1);
            status_clr = 4'hF;
            tick(1);
            status_clr = 4'h0;
            tick(1);
            chk("R4 status cleared", 32'(buf_status), 0);
        end

        // R4 R5 set wins over a held clear, no overflow
        buf_size = 8'd16;
        stall_mode = 1'b1;
        status_clr = 4'hF;
        trace_en = 1'b1;
        tick(1);
        chk("R8 overflow cleared on start", 32'(overflow), 0);
        for (int r = 0; r < 10; r++) repeat (REC) push();
        trace_en = 1'b0;
        tick(3);
        chk("R5 no overflow when acknowledged", 32'(overflow), 0);
        status_clr = 4'h0;

        // R6 R7 R8 stop in mid-record, hold, restart
        stall_mode = 1'b0;
        buf_size = 8'd24;
        trace_en = 1'b1;
        tick(1);
        repeat (REC + 1) push();
        trace_en = 1'b0;
        push();
        tick(2);
        chk("R6 drained offset", 32'(cur_off), 16);
        rec_valid = 1'b1;
        rec_data = 32'hDEAD;
        tick(4);
        chk("R7 held offset", 32'(cur_off), 16);
        chk("R7 held index", 32'(cur_idx), 0);
        rec_valid = 1'b0;
        tick(1);
        trace_en = 1'b1;
        tick(1);
        chk("R8 restart offset", 32'(cur_off), 0);
        chk("R8 restart index", 32'(cur_idx), 0);
        repeat (REC * 4) push();
        trace_en = 1'b0;
        tick(3);
        chk("R2 index after 8 words of 24B buffers", 32'(cur_idx), 1);
        chk("R1 offset after 8 words", 32'(cur_off), 8);
        finish_run();
    end
endmodule